// File: doc/BRIEF.md
# Gen2 Link-Speed Stall Recovery Monitor

This block sits beside a PCIe link controller. It watches the two 32-bit words that the PHY and MAC expose for debugging. It decides whether the link is up, and it recognises one failure. The failure is this: a move to the second-generation link speed has stalled in the receiver-lock state of recovery, and the PHY's receiver reports no valid data. When it sees that case, it kicks the receiver by driving two receive override enables high in an indirectly addressed PHY register, holding them there for a fixed time, and then dropping them again.

The PHY registers are not memory mapped. Every access goes through an external access master. The block raises a request with an address, a direction and write data, and holds it until the master returns a one-cycle done strobe, with read data for reads. Setting and clearing the overrides are both read-modify-write operations, so other bits of the override register are preserved.

After the LTSSM enters L0, a settle window must pass before the block arms. This gives a speed change time to complete. Each recovery it starts disarms it until the next L0 entry, so a stuck link gets at most one kick per L0 entry.

Top module: `gen2_stall_recovery`

## Requirements
- R1: `link_up_o` equals bit 4 of `dbg_hi_i`, which is bit 36 of the 64-bit debug vector. No other debug bit affects it.
- R2: No PHY access is requested until `SETTLE_CYCLES` cycles after the LTSSM field enters L0 (code 6'h11 by default). A fresh L0 entry restarts the window and disarms the block.
- R3: When armed, with link down and the LTSSM field (bits 5:0 of `dbg_lo_i`) equal to the receiver-lock code (6'h0D by default), the block requests a read of PHY address 0x100D. In any other LTSSM state it requests no access.
- R4: If bit 0 of the 0x100D read data is 1, no recovery starts and the override register is never written.
- R5: If bit 0 of the 0x100D read data is 0 and the trigger condition still holds, `stall_o` pulses for exactly one cycle. In that same cycle a read of PHY address 0x1005 is requested.
- R6: The first write to 0x1005 carries the value just read, with bits 5 and 3 set and every other bit unchanged.
- R7: `hold_o` is high for exactly `HOLD_CYCLES` cycles after the set write completes. After that, 0x1005 is read again and written back with bits 5 and 3 cleared and all other bits unchanged.
- R8: While `link_up_o` is 1, no check or recovery is started.
- R9: After a recovery has started, no further recovery happens until a new L0 entry and settle window.
- R10: Only one access is outstanding at a time. Request, direction, address and write data stay stable until the done strobe.
- R11: During and right after reset, `acc_req_o`, `stall_o` and `hold_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dbg_lo_i | input | 32 | Lower debug word; LTSSM state in bits 5:0 |
| dbg_hi_i | input | 32 | Upper debug word; link-up flag in bit 4 |
| link_up_o | output | 1 | Link-up flag |
| acc_req_o | output | 1 | PHY register access request |
| acc_we_o | output | 1 | 1 = write, 0 = read |
| acc_addr_o | output | 16 | PHY register address |
| acc_wdata_o | output | 16 | Write data |
| acc_done_i | input | 1 | One-cycle completion strobe from the access master |
| acc_rdata_i | input | 16 | Read data, valid with `acc_done_i` |
| stall_o | output | 1 | One-cycle pulse when a recovery begins |
| hold_o | output | 1 | High while the overrides are being held |

## Verification
The assertions assume an access master with these properties:
- It raises `acc_done_i` for exactly one cycle per request, and only while a request is pending.
- It presents read data in the same cycle as `acc_done_i`.

The debug words may change freely, even while an access is pending.

The bench meets these assumptions with a responder that answers each request once, after a fixed latency, from a small model of the two PHY registers. It changes the LTSSM field only at falling edges, and it leaves enough cycles for every access to finish before the next scenario starts.

// File: rtl/srm_pkg.sv
package srm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_RXV,
    ST_RD_SET,
    ST_WR_SET,
    ST_HOLD,
    ST_RD_CLR,
    ST_WR_CLR
  } srm_state_e;

endpackage

// File: rtl/srm_reset_sync.sv
module srm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/srm_link_decode.sv
module srm_link_decode #(
  parameter int                DBG_W         = 32,
  parameter int                LTSSM_W       = 6,
  parameter int                LINK_BIT      = 4,
  parameter logic [LTSSM_W-1:0] L0_CODE      = 6'h11,
  parameter int                SETTLE_CYCLES = 250000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DBG_W-1:0]   dbg_lo_i,
  input  logic [DBG_W-1:0]   dbg_hi_i,
  input  logic               disarm_i,
  output logic               link_up_o,
  output logic [LTSSM_W-1:0] ltssm_o,
  output logic               armed_o
);

  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES - 1);

  logic          in_l0;
  logic          prev_l0_q;
  logic          l0_entry;
  logic [SW-1:0] cnt_q, cnt_d;
  logic          counting_q, counting_d;
  logic          armed_q, armed_d;
  logic          cnt_en;
  logic          unused_dbg;

  assign ltssm_o    = dbg_lo_i[LTSSM_W-1:0];
  assign link_up_o  = dbg_hi_i[LINK_BIT];
  assign unused_dbg = ^{dbg_lo_i[DBG_W-1:LTSSM_W], dbg_hi_i};
  assign in_l0      = (ltssm_o == L0_CODE);
  assign l0_entry   = in_l0 && !prev_l0_q;
  assign cnt_en     = l0_entry || counting_q;

  // Next-state logic of the settle window.
  always_comb begin
    cnt_d      = cnt_q;
    counting_d = counting_q;
    armed_d    = armed_q;
    if (l0_entry) begin
      cnt_d      = '0;
      counting_d = 1'b1;
      armed_d    = 1'b0;
    end else begin
      if (counting_q) begin
        if (cnt_q == SETTLE_LAST) begin
          counting_d = 1'b0;
          armed_d    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (disarm_i) begin
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_l0_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      prev_l0_q <= in_l0;
      armed_q   <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      counting_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q      <= cnt_d;
      counting_q <= counting_d;
    end
  end

  assign armed_o = armed_q;

  // R2
  entry_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l0_entry |=> !armed_o);

  // R9
  disarm_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm_i && !l0_entry) |=> !armed_o);

endmodule

// File: rtl/srm_hold_timer.sv
module srm_hold_timer #(
  parameter int HOLD_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);

  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) begin
      cnt_d = HOLD_LAST;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

  // R7
  hold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= HOLD_LAST);

  // R7
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == HOLD_LAST));

endmodule

// File: rtl/srm_recovery_seq.sv
module srm_recovery_seq
  import srm_pkg::*;
#(
  parameter int                 LTSSM_W      = 6,
  parameter int                 PHY_AW       = 16,
  parameter int                 PHY_DW       = 16,
  parameter logic [LTSSM_W-1:0] RCVLOCK_CODE = 6'h0D,
  parameter logic [PHY_AW-1:0]  RXASIC_ADDR  = 16'h100D,
  parameter logic [PHY_AW-1:0]  OVR_ADDR     = 16'h1005,
  parameter int                 RXVALID_BIT  = 0,
  parameter int                 DATA_EN_BIT  = 5,
  parameter int                 PLL_EN_BIT   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               armed_i,
  input  logic               link_up_i,
  input  logic [LTSSM_W-1:0] ltssm_i,
  input  logic               acc_done_i,
  input  logic [PHY_DW-1:0]  acc_rdata_i,
  input  logic               hold_expired_i,
  output logic               acc_req_o,
  output logic               acc_we_o,
  output logic [PHY_AW-1:0]  acc_addr_o,
  output logic [PHY_DW-1:0]  acc_wdata_o,
  output logic               stall_o,
  output logic               hold_o,
  output logic               hold_load_o,
  output logic               disarm_o
);

  localparam logic [PHY_DW-1:0] OVR_MASK =
    (PHY_DW'(1) << DATA_EN_BIT) | (PHY_DW'(1) << PLL_EN_BIT);

  srm_state_e        state_q, state_d;
  logic [PHY_DW-1:0] data_q, data_d;
  logic              data_en;
  logic              stall_q, stall_d;
  logic              trigger;

  assign trigger = armed_i && !link_up_i && (ltssm_i == RCVLOCK_CODE);

  // Next-state process.
  always_comb begin
    state_d     = state_q;
    data_d      = data_q;
    data_en     = 1'b0;
    stall_d     = 1'b0;
    hold_load_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (trigger) begin
          state_d = ST_RD_RXV;
        end
      end
      ST_RD_RXV: begin
        if (acc_done_i) begin
          if (!acc_rdata_i[RXVALID_BIT] && trigger) begin
            state_d = ST_RD_SET;
            stall_d = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_RD_SET: begin
        if (acc_done_i) begin
          data_d  = acc_rdata_i | OVR_MASK;
          data_en = 1'b1;
          state_d = ST_WR_SET;
        end
      end
      ST_WR_SET: begin
        if (acc_done_i) begin
          hold_load_o = 1'b1;
          state_d     = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (hold_expired_i) begin
          state_d = ST_RD_CLR;
        end
      end
      ST_RD_CLR: begin
        if (acc_done_i) begin
          data_d  = acc_rdata_i & ~OVR_MASK;
          data_en = 1'b1;
          state_d = ST_WR_CLR;
        end
      end
      ST_WR_CLR: begin
        if (acc_done_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stall_q <= 1'b0;
    end else begin
      state_q <= state_d;
      stall_q <= stall_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign disarm_o = stall_d;
  assign stall_o  = stall_q;
  assign hold_o   = (state_q == ST_HOLD);

  always_comb begin
    acc_req_o   = 1'b0;
    acc_we_o    = 1'b0;
    acc_addr_o  = OVR_ADDR;
    acc_wdata_o = '0;
    case (state_q)
      ST_RD_RXV: begin
        acc_req_o  = 1'b1;
        acc_addr_o = RXASIC_ADDR;
      end
      ST_RD_SET, ST_RD_CLR: begin
        acc_req_o = 1'b1;
      end
      ST_WR_SET, ST_WR_CLR: begin
        acc_req_o   = 1'b1;
        acc_we_o    = 1'b1;
        acc_wdata_o = data_q;
      end
      default: ;
    endcase
  end

  // R10
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req_o && !acc_done_i) |=>
      (acc_req_o && $stable(acc_we_o) && $stable(acc_addr_o) && $stable(acc_wdata_o)));

  // R4
  stall_needs_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> ($past(acc_done_i) && !$past(acc_rdata_i[RXVALID_BIT])));

  // R5
  stall_reads_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (acc_req_o && !acc_we_o && (acc_addr_o == OVR_ADDR)));

  // R2
  check_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(acc_req_o) && (acc_addr_o == RXASIC_ADDR)) |-> $past(armed_i));

  // R8
  no_check_link_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(acc_req_o) && (acc_addr_o == RXASIC_ADDR)) |-> !$past(link_up_i));

  // R6
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> ($past(acc_we_o) && (($past(acc_wdata_o) & OVR_MASK) == OVR_MASK)));

  // R7
  clear_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> (acc_req_o && !acc_we_o && (acc_addr_o == OVR_ADDR)));

endmodule

// File: rtl/gen2_stall_recovery.sv
module gen2_stall_recovery #(
  parameter int          DBG_W         = 32,
  parameter int          LTSSM_W       = 6,
  parameter int          LINK_BIT      = 4,
  parameter int          PHY_AW        = 16,
  parameter int          PHY_DW        = 16,
  parameter logic [5:0]  L0_CODE       = 6'h11,
  parameter logic [5:0]  RCVLOCK_CODE  = 6'h0D,
  parameter logic [15:0] RXASIC_ADDR   = 16'h100D,
  parameter logic [15:0] OVR_ADDR      = 16'h1005,
  parameter int          RXVALID_BIT   = 0,
  parameter int          DATA_EN_BIT   = 5,
  parameter int          PLL_EN_BIT    = 3,
  parameter int          SETTLE_CYCLES = 250000,
  parameter int          HOLD_CYCLES   = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DBG_W-1:0]  dbg_lo_i,
  input  logic [DBG_W-1:0]  dbg_hi_i,
  output logic              link_up_o,
  output logic              acc_req_o,
  output logic              acc_we_o,
  output logic [PHY_AW-1:0] acc_addr_o,
  output logic [PHY_DW-1:0] acc_wdata_o,
  input  logic              acc_done_i,
  input  logic [PHY_DW-1:0] acc_rdata_i,
  output logic              stall_o,
  output logic              hold_o
);

  logic               rst_sync_n;
  logic [LTSSM_W-1:0] ltssm;
  logic               armed;
  logic               disarm;
  logic               hold_load;
  logic               hold_expired;

  srm_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  srm_link_decode #(
    .DBG_W         (DBG_W),
    .LTSSM_W       (LTSSM_W),
    .LINK_BIT      (LINK_BIT),
    .L0_CODE       (LTSSM_W'(L0_CODE)),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .dbg_lo_i  (dbg_lo_i),
    .dbg_hi_i  (dbg_hi_i),
    .disarm_i  (disarm),
    .link_up_o (link_up_o),
    .ltssm_o   (ltssm),
    .armed_o   (armed)
  );

  srm_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (hold_load),
    .expired_o (hold_expired)
  );

  srm_recovery_seq #(
    .LTSSM_W      (LTSSM_W),
    .PHY_AW       (PHY_AW),
    .PHY_DW       (PHY_DW),
    .RCVLOCK_CODE (LTSSM_W'(RCVLOCK_CODE)),
    .RXASIC_ADDR  (PHY_AW'(RXASIC_ADDR)),
    .OVR_ADDR     (PHY_AW'(OVR_ADDR)),
    .RXVALID_BIT  (RXVALID_BIT),
    .DATA_EN_BIT  (DATA_EN_BIT),
    .PLL_EN_BIT   (PLL_EN_BIT)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .armed_i        (armed),
    .link_up_i      (link_up_o),
    .ltssm_i        (ltssm),
    .acc_done_i     (acc_done_i),
    .acc_rdata_i    (acc_rdata_i),
    .hold_expired_i (hold_expired),
    .acc_req_o      (acc_req_o),
    .acc_we_o       (acc_we_o),
    .acc_addr_o     (acc_addr_o),
    .acc_wdata_o    (acc_wdata_o),
    .stall_o        (stall_o),
    .hold_o         (hold_o),
    .hold_load_o    (hold_load),
    .disarm_o       (disarm)
  );

  // R11
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (!acc_req_o && !stall_o && !hold_o));

endmodule

// File: tb/gen2_stall_recovery_bench.sv
module gen2_stall_recovery_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 40;
  localparam int HOLD       = 30;
  localparam int LAT        = 2;
  localparam logic [5:0]  L0   = 6'h11;
  localparam logic [5:0]  RCV  = 6'h0D;
  localparam logic [15:0] RXA  = 16'h100D;
  localparam logic [15:0] OVR  = 16'h1005;
  localparam logic [15:0] MASK = 16'h0028;

  // {link, rx_value, ovr_initial, expect_recovery}
  localparam logic [33:0] VEC [0:5] = '{
    {1'b0, 16'h0000, 16'h0000, 1'b1},
    {1'b0, 16'h0001, 16'h1234, 1'b0},
    {1'b1, 16'h0000, 16'h0000, 1'b0},
    {1'b0, 16'hFFFE, 16'hFFD7, 1'b1},
    {1'b0, 16'h0002, 16'h0028, 1'b1},
    {1'b0, 16'h8001, 16'hA5A5, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] dbg_lo, dbg_hi;
  logic        link_up, acc_req, acc_we, acc_done, stall, hold;
  logic [15:0] acc_addr, acc_wdata, acc_rdata;

  int total, bad;
  int stall_cnt, hold_cnt, rd_rx_cnt, wr_cnt;
  logic [15:0] wr_val [0:1];
  logic [15:0] ovr_reg, rx_reg;
  bit finished;

  gen2_stall_recovery #(
    .SETTLE_CYCLES (SETTLE),
    .HOLD_CYCLES   (HOLD)
  ) u_gen2_stall_recovery (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbg_lo_i    (dbg_lo),
    .dbg_hi_i    (dbg_hi),
    .link_up_o   (link_up),
    .acc_req_o   (acc_req),
    .acc_we_o    (acc_we),
    .acc_addr_o  (acc_addr),
    .acc_wdata_o (acc_wdata),
    .acc_done_i  (acc_done),
    .acc_rdata_i (acc_rdata),
    .stall_o     (stall),
    .hold_o      (hold)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY access responder: one done pulse per request after LAT cycles.
  initial begin
    acc_done  = 1'b0;
    acc_rdata = '0;
    forever begin
      @(negedge clk);
      acc_done = 1'b0;
      if (acc_req) begin
        repeat (LAT) @(negedge clk);
        if (acc_we) begin
          if (acc_addr == OVR) ovr_reg = acc_wdata;
          if (wr_cnt < 2) wr_val[wr_cnt] = acc_wdata;
          wr_cnt++;
          acc_rdata = '0;
        end else begin
          if (acc_addr == RXA) begin
            rd_rx_cnt++;
            acc_rdata = rx_reg;
          end else if (acc_addr == OVR) begin
            acc_rdata = ovr_reg;
          end else begin
            acc_rdata = '0;
          end
        end
        acc_done = 1'b1;
      end
    end
  end

  // Output monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (stall) stall_cnt++;
      if (hold) hold_cnt++;
    end
  end

  task automatic clear_logs();
    stall_cnt = 0;
    hold_cnt  = 0;
    rd_rx_cnt = 0;
    wr_cnt    = 0;
    wr_val[0] = '0;
    wr_val[1] = '0;
  endtask

  task automatic set_ltssm(input logic [5:0] code);
    dbg_lo = 32'h5A5A_5AC0 | {26'd0, code};
  endtask

  task automatic run_vec(input int idx, input logic lnk, input logic [15:0] rx,
                         input logic [15:0] ovr, input logic exp_rec);
    set_ltssm(6'h00);
    dbg_hi = 32'h0;
    repeat (20) @(negedge clk);
    rx_reg  = rx;
    ovr_reg = ovr;
    clear_logs();
    set_ltssm(L0);
    repeat (SETTLE + 5) @(negedge clk);
    set_ltssm(RCV);
    dbg_hi = {27'd0, lnk, 4'd0};
    repeat (160) @(negedge clk);
    $display("vector %0d", idx);
    chk("R5 stall pulses", stall_cnt, exp_rec ? 1 : 0);
    if (exp_rec) begin
      chk("R6 write count", wr_cnt, 2);
      chk("R6 set value", wr_val[0], ovr | MASK);
      chk("R7 clear value", wr_val[1], ovr & ~MASK);
      chk("R7 hold length", hold_cnt, HOLD);
      chk("R7 final override", ovr_reg, ovr & ~MASK);
    end else begin
      chk("R4 no write", wr_cnt, 0);
      chk("R4 override untouched", ovr_reg, ovr);
      chk("R4 hold idle", hold_cnt, 0);
    end
    if (lnk) chk("R8 no check while up", rd_rx_cnt, 0);
    else     chk("R3 check issued", (rd_rx_cnt > 0) ? 1 : 0, 1);
    set_ltssm(6'h00);
    dbg_hi = 32'h0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0;
    bad = 0;
    finished = 0;
    rst_n = 1'b0;
    dbg_lo = '0;
    dbg_hi = '0;
    rx_reg = '0;
    ovr_reg = '0;
    clear_logs();

    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 req in reset", acc_req, 0);
    chk("R11 stall in reset", stall, 0);
    chk("R11 hold in reset", hold, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 req after reset", acc_req, 0);
    chk("R11 stall after reset", stall, 0);
    chk("R11 hold after reset", hold, 0);

    // R1: link-up decoding
    dbg_hi = 32'h0000_0010;
    @(negedge clk);
    chk("R1 link bit set", link_up, 1);
    dbg_hi = 32'hFFFF_FFEF;
    @(negedge clk);
    chk("R1 other bits", link_up, 0);
    dbg_hi = 32'h0;
    dbg_lo = 32'h0000_0010;
    @(negedge clk);
    chk("R1 wrong word", link_up, 0);
    set_ltssm(6'h00);
    repeat (5) @(negedge clk);

    // Table walk
    for (int i = 0; i < 6; i++) begin
      run_vec(i, VEC[i][33], VEC[i][32:17], VEC[i][16:1], VEC[i][0]);
    end

    // R2: settle window after L0 entry
    rx_reg = 16'h0000;
    ovr_reg = 16'h0100;
    clear_logs();
    set_ltssm(L0);
    repeat (2) @(negedge clk);
    set_ltssm(RCV);
    repeat (25) @(negedge clk);
    chk("R2 no access while settling", rd_rx_cnt + wr_cnt, 0);
    repeat (100) @(negedge clk);
    chk("R2 recovery after settle", stall_cnt, 1);
    chk("R6 set after settle", wr_val[0], 16'h0128);

    // R9: stays stuck in receiver lock, no new L0 entry
    repeat (200) @(negedge clk);
    chk("R9 single recovery", stall_cnt, 1);
    chk("R9 no further checks", rd_rx_cnt, 1);

    // R3: armed, link down, rx invalid, but another LTSSM state
    set_ltssm(6'h00);
    repeat (10) @(negedge clk);
    clear_logs();
    set_ltssm(L0);
    repeat (SETTLE + 5) @(negedge clk);
    set_ltssm(6'h0E);
    repeat (100) @(negedge clk);
    chk("R3 other state no access", rd_rx_cnt + wr_cnt, 0);
    set_ltssm(RCV);
    repeat (10) @(negedge clk);
    chk("R3 receiver lock triggers", stall_cnt, 1);
    repeat (100) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule